// File: doc/BRIEF.md
# Banked Stack-Pointer Control Register File

This unit holds a processor's control registers and serves them through one combinational read port and one clocked write port. Each port is addressed by a 4-bit control-register number. It packs the status word from three stored fields: a status byte, a backup status byte and a condition bit. It also keeps a backup-backup status byte, two backup program counters and two spare 32-bit registers.

The stack pointer is banked. The live copy sits in general register 15, outside this unit, and is reached through a side port. The unit reads the live value on `sp_live_i`. It overwrites the live value by driving `sp_live_o` and pulsing `sp_live_we` for one cycle, and the general register file loads it on that clock edge. Bit 7 of the status byte is the stack mode. It decides whether the interrupt or the user stack-pointer register stands for the live value. Any status write that changes this bit parks the live value in the bank it leaves and reloads the live value from the bank it enters.

Register numbers: 0 status, 1 condition bit, 2 interrupt stack pointer, 3 user stack pointer, 4 spare A, 5 spare B, 6 backup PC, 7 backup-backup status, 8 backup-backup PC, and 9 to 15 unassigned.

Top module: `crf_top`

## Requirements
- R1: After reset every stored field, including the mode bit, is 0, so every register number reads 0 while the live stack pointer is 0.
- R2: Reading register 0 returns backup status AND 0xC1 in bits 15:8, status AND 0xC0 in bits 7:0 with the condition bit placed in bit 0, and 0 in bits 31:16.
- R3: Writing register 0 loads data bits 15:8 into the backup status byte, bits 7:0 into the status byte and bit 0 into the condition bit.
- R4: A register 0 write that moves the mode bit from 0 to 1 stores the live stack pointer into the interrupt copy, drives the user copy on `sp_live_o` and pulses `sp_live_we` in that cycle.
- R5: A register 0 write that moves the mode bit from 1 to 0 stores the live stack pointer into the user copy, drives the interrupt copy on `sp_live_o` and pulses `sp_live_we` in that cycle.
- R6: Register 2 reads and writes the live stack pointer while the mode is 0, and the stored interrupt copy while the mode is 1.
- R7: Register 3 reads and writes the live stack pointer while the mode is 1, and the stored user copy while the mode is 0.
- R8: Registers 6 and 8 store all 32 bits written but always read back with bit 0 equal to 0.
- R9: Register 7 stores data bits 7:0 and reads back that byte AND 0xC1, zero-extended.
- R10: Register 1 reads as the condition bit (bit 0, other bits 0) and its write takes the condition bit from data bit 0.
- R11: Registers 4 and 5 are plain 32-bit storage. Registers 9 to 15 read 0, and writes to them change no register and do not touch the live stack pointer.
- R12: A write takes effect on the clock edge, so a read in the same cycle returns the old value. `sp_live_we` is high only in a cycle that carries a redirected stack-pointer write or a mode swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_idx | input | 4 | Control-register number to read |
| rd_data | output | 32 | Read data, combinational from current state |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Control-register number to write |
| wr_data | input | 32 | Write data |
| sp_live_i | input | 32 | Current value of the live stack-pointer general register |
| sp_live_o | output | 32 | New value for the live stack pointer |
| sp_live_we | output | 1 | Load strobe for the live stack pointer |

## Verification
The bench sweeps every register number with several data patterns. Some of those patterns flip the mode bit, so the redirect paths for registers 2 and 3 are checked in both modes and both swap directions. A design that inverted the redirect sense, or swapped the wrong bank, would show up in two places: the bench's own copy of general register 15 would diverge, and a later read of the parked copy would return the wrong value. The bench also checks the hidden bits of the status and PC reads, the silence of unassigned numbers, and old-value reads in the write cycle. These catch a missing read mask, a write that leaks into an unassigned number, and a read port that bypasses the write.

// File: rtl/crf_pkg.sv
package crf_pkg;
    localparam int XLEN  = 32;
    localparam int IDX_W = 4;

    typedef logic [IDX_W-1:0] cr_idx_t;

    localparam cr_idx_t CR_STAT    = 4'd0;
    localparam cr_idx_t CR_COND    = 4'd1;
    localparam cr_idx_t CR_ISP     = 4'd2;
    localparam cr_idx_t CR_USP     = 4'd3;
    localparam cr_idx_t CR_SPARE_A = 4'd4;
    localparam cr_idx_t CR_SPARE_B = 4'd5;
    localparam cr_idx_t CR_BPC     = 4'd6;
    localparam cr_idx_t CR_BBSTAT  = 4'd7;
    localparam cr_idx_t CR_BBPC    = 4'd8;
    localparam cr_idx_t CR_LAST    = CR_BBPC;

    localparam logic [7:0] STAT_RD_MASK  = 8'hC0;
    localparam logic [7:0] BSTAT_RD_MASK = 8'hC1;
    localparam int         MODE_BIT      = 7;

    // slot order inside the plain store
    localparam int SLOT_BPC     = 0;
    localparam int SLOT_BBPC    = 1;
    localparam int SLOT_SPARE_A = 2;
    localparam int SLOT_SPARE_B = 3;
    localparam int N_SLOT       = 4;

    typedef struct packed {
        logic [7:0] bstat;
        logic [7:0] stat;
        logic       cond;
        logic [7:0] bbstat;
    } stat_state_t;
endpackage

// File: rtl/crf_status_unit.sv
module crf_status_unit
    import crf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stat_we,
    input  logic        cond_we,
    input  logic        bbstat_we,
    input  logic [15:0] wdata,
    output logic        mode_q,
    output logic [15:0] rd_stat,
    output logic        rd_cond,
    output logic [7:0]  rd_bbstat
);
    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stat_we) begin
            st_d.bstat = wdata[15:8];
            st_d.stat  = wdata[7:0];
            st_d.cond  = wdata[0];
        end
        if (cond_we) begin
            st_d.cond = wdata[0];
        end
        if (bbstat_we) begin
            st_d.bbstat = wdata[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_q    = st_q.stat[MODE_BIT];
    assign rd_stat   = {st_q.bstat & BSTAT_RD_MASK,
                        (st_q.stat & STAT_RD_MASK) | {7'b0, st_q.cond}};
    assign rd_cond   = st_q.cond;
    assign rd_bbstat = st_q.bbstat & BSTAT_RD_MASK;

    // mode only moves through a status write
    p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_we |=> $stable(mode_q));

    // condition bit follows bit 0 of its own write
    p_cond_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_we && !stat_we) |=> rd_cond == $past(wdata[0]));

    // backup-backup status only changes on its own write
    p_bbstat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bbstat_we |=> $stable(rd_bbstat));
endmodule

// File: rtl/crf_sp_bank.sv
module crf_sp_bank
    import crf_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_q,
    input  logic         mode_new,
    input  logic         stat_we,
    input  logic         isp_we,
    input  logic         usp_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] sp_live_i,
    output logic [W-1:0] sp_live_o,
    output logic         sp_live_we,
    output logic [W-1:0] rd_isp,
    output logic [W-1:0] rd_usp
);
    typedef struct packed {
        logic [W-1:0] isp;
        logic [W-1:0] usp;
    } bank_t;

    bank_t bk_d, bk_q;
    logic  flip_up, flip_dn;

    assign flip_up = stat_we && !mode_q &&  mode_new;
    assign flip_dn = stat_we &&  mode_q && !mode_new;

    always_comb begin
        bk_d       = bk_q;
        sp_live_o  = '0;
        sp_live_we = 1'b0;
        if (flip_up) begin
            bk_d.isp   = sp_live_i;
            sp_live_o  = bk_q.usp;
            sp_live_we = 1'b1;
        end
        if (flip_dn) begin
            bk_d.usp   = sp_live_i;
            sp_live_o  = bk_q.isp;
            sp_live_we = 1'b1;
        end
        if (isp_we) begin
            if (!mode_q) begin
                sp_live_o  = wdata;
                sp_live_we = 1'b1;
            end else begin
                bk_d.isp = wdata;
            end
        end
        if (usp_we) begin
            if (mode_q) begin
                sp_live_o  = wdata;
                sp_live_we = 1'b1;
            end else begin
                bk_d.usp = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign rd_isp = mode_q ? bk_q.isp : sp_live_i;
    assign rd_usp = mode_q ? sp_live_i : bk_q.usp;

    p_swap_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flip_up |=> bk_q.isp == $past(sp_live_i));

    p_swap_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flip_dn |=> bk_q.usp == $past(sp_live_i));

    p_isp_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (isp_we && mode_q) |=> bk_q.isp == $past(wdata));

    p_usp_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (usp_we && !mode_q) |=> bk_q.usp == $past(wdata));

    p_live_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sp_live_we |-> (stat_we || isp_we || usp_we));

    p_bank_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_we || isp_we || usp_we) |=> $stable(bk_q));
endmodule

// File: rtl/crf_plain_store.sv
module crf_plain_store
    import crf_pkg::*;
#(
    parameter int                W       = XLEN,
    parameter int                NS      = N_SLOT,
    parameter logic [NS-1:0]     CLR_LSB = 4'b0011
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NS-1:0]   slot_we,
    input  logic [W-1:0]    wdata,
    output logic [NS*W-1:0] rd_slots
);
    logic [W-1:0] slot_d [NS];
    logic [W-1:0] slot_q [NS];

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            slot_d[i] = slot_we[i] ? wdata : slot_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) slot_q[i] <= '0;
        end else begin
            for (int i = 0; i < NS; i++) slot_q[i] <= slot_d[i];
        end
    end

    for (genvar g = 0; g < NS; g++) begin : g_slot
        if (CLR_LSB[g]) begin : g_pc
            assign rd_slots[g*W +: W] = {slot_q[g][W-1:1], 1'b0};

            p_pc_lsb_r8: assert property (@(posedge clk) disable iff (!rst_n)
                slot_we[g] |=> (rd_slots[g*W+1 +: W-1] == $past(wdata[W-1:1]))
                               && !rd_slots[g*W]);
        end else begin : g_raw
            assign rd_slots[g*W +: W] = slot_q[g];

            p_raw_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
                slot_we[g] |=> rd_slots[g*W +: W] == $past(wdata));
        end
    end
endmodule

// File: rtl/crf_top.sv
module crf_top
    import crf_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [W-1:0]     sp_live_i,
    output logic [W-1:0]     sp_live_o,
    output logic             sp_live_we
);
    logic              stat_we, cond_we, bbstat_we, isp_we, usp_we;
    logic [N_SLOT-1:0] slot_we;
    logic              mode_q;
    logic [15:0]       rd_stat;
    logic              rd_cond;
    logic [7:0]        rd_bbstat;
    logic [W-1:0]      rd_isp, rd_usp;
    logic [N_SLOT*W-1:0] rd_slots;

    always_comb begin
        stat_we   = wr_en && (wr_idx == CR_STAT);
        cond_we   = wr_en && (wr_idx == CR_COND);
        bbstat_we = wr_en && (wr_idx == CR_BBSTAT);
        isp_we    = wr_en && (wr_idx == CR_ISP);
        usp_we    = wr_en && (wr_idx == CR_USP);
        slot_we   = '0;
        slot_we[SLOT_BPC]     = wr_en && (wr_idx == CR_BPC);
        slot_we[SLOT_BBPC]    = wr_en && (wr_idx == CR_BBPC);
        slot_we[SLOT_SPARE_A] = wr_en && (wr_idx == CR_SPARE_A);
        slot_we[SLOT_SPARE_B] = wr_en && (wr_idx == CR_SPARE_B);
    end

    crf_status_unit u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_we   (stat_we),
        .cond_we   (cond_we),
        .bbstat_we (bbstat_we),
        .wdata     (wr_data[15:0]),
        .mode_q    (mode_q),
        .rd_stat   (rd_stat),
        .rd_cond   (rd_cond),
        .rd_bbstat (rd_bbstat)
    );

    crf_sp_bank #(.W(W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_q     (mode_q),
        .mode_new   (wr_data[MODE_BIT]),
        .stat_we    (stat_we),
        .isp_we     (isp_we),
        .usp_we     (usp_we),
        .wdata      (wr_data),
        .sp_live_i  (sp_live_i),
        .sp_live_o  (sp_live_o),
        .sp_live_we (sp_live_we),
        .rd_isp     (rd_isp),
        .rd_usp     (rd_usp)
    );

    crf_plain_store #(
        .W       (W),
        .NS      (N_SLOT),
        .CLR_LSB (N_SLOT'((1 << SLOT_BPC) | (1 << SLOT_BBPC)))
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_we  (slot_we),
        .wdata    (wr_data),
        .rd_slots (rd_slots)
    );

    always_comb begin
        rd_data = '0;
        case (rd_idx)
            CR_STAT:    rd_data = {{(W-16){1'b0}}, rd_stat};
            CR_COND:    rd_data = {{(W-1){1'b0}}, rd_cond};
            CR_ISP:     rd_data = rd_isp;
            CR_USP:     rd_data = rd_usp;
            CR_SPARE_A: rd_data = rd_slots[SLOT_SPARE_A*W +: W];
            CR_SPARE_B: rd_data = rd_slots[SLOT_SPARE_B*W +: W];
            CR_BPC:     rd_data = rd_slots[SLOT_BPC*W +: W];
            CR_BBSTAT:  rd_data = {{(W-8){1'b0}}, rd_bbstat};
            CR_BBPC:    rd_data = rd_slots[SLOT_BBPC*W +: W];
            default:    rd_data = '0;
        endcase
    end

    p_unassigned_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx > CR_LAST)) |-> !sp_live_we);

    p_status_high_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == CR_STAT) |-> (rd_data[W-1:16] == '0) && (rd_data[5:1] == '0)
                                && (rd_data[13:9] == '0));
endmodule

// File: tb/sim_crf_top.sv
module sim_crf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] gpr_sp;
    logic [31:0] sp_live_o;
    logic        sp_live_we;

    int total = 0;
    int bad   = 0;

    // bench model of the registers
    logic [7:0]  m_bstat, m_stat, m_bbstat;
    logic        m_cond;
    logic [31:0] m_isp, m_usp, m_sp, m_bpc, m_bbpc, m_spa, m_spb;

    always #10 clk = ~clk;

    crf_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .sp_live_i  (gpr_sp),
        .sp_live_o  (sp_live_o),
        .sp_live_we (sp_live_we)
    );

    // stand-in for general register 15
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          gpr_sp <= '0;
        else if (sp_live_we) gpr_sp <= sp_live_o;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(input logic [3:0] idx);
        logic md = m_stat[7];
        case (idx)
            4'd0: return {16'b0, m_bstat & 8'hC1, (m_stat & 8'hC0) | {7'b0, m_cond}};
            4'd1: return {31'b0, m_cond};
            4'd2: return md ? m_isp : m_sp;
            4'd3: return md ? m_sp : m_usp;
            4'd4: return m_spa;
            4'd5: return m_spb;
            4'd6: return {m_bpc[31:1], 1'b0};
            4'd7: return {24'b0, m_bbstat & 8'hC1};
            4'd8: return {m_bbpc[31:1], 1'b0};
            default: return 32'b0;
        endcase
    endfunction

    function automatic string rtag(input logic [3:0] idx);
        case (idx)
            4'd0: return "R2 status read";
            4'd1: return "R10 cond read";
            4'd2: return "R6 isp read";
            4'd3: return "R7 usp read";
            4'd4, 4'd5: return "R11 spare read";
            4'd6, 4'd8: return "R8 pc read";
            4'd7: return "R9 bbstat read";
            default: return "R11 unassigned read";
        endcase
    endfunction

    task automatic rd_chk(input logic [3:0] idx, input string tag);
        @(negedge clk);
        rd_idx = idx;
        #1;
        chk(tag, rd_data, mread(idx));
    endtask

    task automatic sweep_reads();
        for (int i = 0; i < 16; i++) rd_chk(4'(i), rtag(4'(i)));
    endtask

    task automatic do_wr(input logic [3:0] idx, input logic [31:0] d);
        logic        md = m_stat[7];
        logic        exp_we = 1'b0;
        logic [31:0] exp_o = '0;
        string       tg = "R12 live strobe";
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d; rd_idx = idx;
        #1;
        chk("R12 old value in write cycle", rd_data, mread(idx));
        case (idx)
            4'd0: begin
                if (!md && d[7]) begin exp_we = 1'b1; exp_o = m_usp; tg = "R4 swap up"; end
                if (md && !d[7]) begin exp_we = 1'b1; exp_o = m_isp; tg = "R5 swap down"; end
            end
            4'd2: if (!md) begin exp_we = 1'b1; exp_o = d; tg = "R6 isp redirect"; end
            4'd3: if (md)  begin exp_we = 1'b1; exp_o = d; tg = "R7 usp redirect"; end
            default: ;
        endcase
        chk(tg, {31'b0, sp_live_we}, {31'b0, exp_we});
        if (exp_we) chk(tg, sp_live_o, exp_o);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        case (idx)
            4'd0: begin
                if (!md && d[7]) begin m_isp = m_sp; m_sp = m_usp; end
                if (md && !d[7]) begin m_usp = m_sp; m_sp = m_isp; end
                m_bstat = d[15:8]; m_stat = d[7:0]; m_cond = d[0];
            end
            4'd1: m_cond = d[0];
            4'd2: if (!md) m_sp = d; else m_isp = d;
            4'd3: if (md) m_sp = d; else m_usp = d;
            4'd4: m_spa = d;
            4'd5: m_spb = d;
            4'd6: m_bpc = d;
            4'd7: m_bbstat = d[7:0];
            4'd8: m_bbpc = d;
            default: ;
        endcase
        chk({tg, " live register"}, gpr_sp, m_sp);
        if (idx == 4'd0) rd_chk(4'd0, "R3 status write fields");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] pats [6];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'h1234_5679;
        pats[3] = 32'h0000_C1BF; pats[4] = 32'hDEAD_BEEF; pats[5] = 32'h8765_3E40;
        m_bstat = '0; m_stat = '0; m_bbstat = '0; m_cond = 1'b0;
        m_isp = '0; m_usp = '0; m_sp = '0; m_bpc = '0; m_bbpc = '0; m_spa = '0; m_spb = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) rd_chk(4'(i), "R1 reset value");
        @(negedge clk); #1;
        chk("R1 idle strobe", {31'b0, sp_live_we}, 32'b0);

        // directed bank swap in both directions
        do_wr(4'd2, 32'h0000_1000);   // mode 0: live
        do_wr(4'd3, 32'h0000_2000);   // mode 0: parked user copy
        do_wr(4'd0, 32'h0000_0080);   // 0->1
        rd_chk(4'd2, "R4 isp holds old live");
        rd_chk(4'd3, "R4 live now user copy");
        do_wr(4'd2, 32'h0000_3000);   // mode 1: parked
        do_wr(4'd3, 32'h0000_4000);   // mode 1: live
        do_wr(4'd0, 32'h0000_0001);   // 1->0
        rd_chk(4'd3, "R5 usp holds old live");
        rd_chk(4'd2, "R5 live now isp copy");
        do_wr(4'd0, 32'h0000_0001);   // no flip
        rd_chk(4'd1, "R10 cond set via status");
        do_wr(4'd1, 32'hFFFF_FFFE);
        rd_chk(4'd1, "R10 cond cleared");

        // unassigned numbers leave everything alone
        for (int k = 9; k < 16; k++) begin
            do_wr(4'(k), 32'hFFFF_FFFF);
            sweep_reads();
        end

        // near-exhaustive sweep: every number under every pattern
        for (int p = 0; p < 6; p++) begin
            for (int i = 0; i < 16; i++) begin
                do_wr(4'(i), pats[p] ^ (32'(i) << 4));
                sweep_reads();
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule